// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Mid-Stop Rearm

This block receives asynchronous serial frames of one start bit, eight data bits and one stop bit on a line that idles high. A free-running oversample strobe, sixteen pulses per bit time by default, paces a tick counter. The counter is aligned to the falling edge that opens each start bit. Every bit is judged near its centre, either from one sample or by a two-of-three vote over three neighbouring samples. The received byte goes into a one-byte holding register, and a ready flag announces it.

The byte is declared complete as soon as the stop bit has been judged at its centre. The receiver then goes straight back to hunting for the next falling edge. It does not wait for the nominal end of its own stop bit. A sender running slightly fast can therefore begin its next start bit while the receiver still counts the second half of the previous stop bit, and no frame is lost. The budget is just under half a bit of slip per frame, which is a few percent of rate mismatch.

The consumer reads the byte and pulses an acknowledge strobe. A low stop sample marks the byte with a framing error but still delivers it. A byte that completes before the previous one was acknowledged replaces it and raises a sticky overrun flag.

Top module: `ovs_uart_rx`

## Requirements
- R1: After reset `rxReady`, `frameErr` and `overrun` are 0, `rxData` is 0, and the receiver is hunting for a start edge.
- R2: A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. On completion the eight data bits appear in `rxData`, with bit 0 being the first bit after the start bit, and `rxReady` becomes 1.
- R3: A falling edge counts as a start bit only if the line is still judged low at the start-bit centre. A low pulse of a quarter bit or less delivers nothing, and the receiver resumes hunting.
- R4: `rxReady` rises at the stop-bit centre. It is still 0 a quarter bit into the stop bit and is already 1 three quarters of the way in.
- R5: The receiver hunts again immediately after the stop-bit centre. A start edge that falls in the second half of the local stop bit is accepted. Back-to-back frames from a sender about 3% fast or slow are all received intact.
- R6: A stop bit judged low sets `frameErr` together with delivering the byte. The next frame with a high stop bit clears `frameErr`.
- R7: A byte that completes while `rxReady` is still 1 and no acknowledge arrives sets `overrun` and overwrites `rxData`. `overrun` stays set until an acknowledge.
- R8: A one-cycle `ack` clears `rxReady` (and `overrun`). `rxData` changes only when a new byte completes.
- R9: With voting enabled (`VOTE`=1), each bit is the majority of the samples at ticks 6, 7 and 8 of the bit. A one-sample glitch at a data-bit centre does not change the received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Oversample strobe, OVS pulses per bit time |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| ack | input | 1 | One-cycle acknowledge of the held byte |
| rxData | output | DATA_BITS | Holding register with the last received byte |
| rxReady | output | 1 | A byte is held and not yet acknowledged |
| frameErr | output | 1 | The held byte had a low stop sample |
| overrun | output | 1 | Sticky: a byte was overwritten before acknowledge |

## Verification
The hardest condition to reach is a start edge that lands inside the second half of the receiver's own stop bit. Such an edge appears only when a sender runs faster than the local bit time and sends frames with no idle gap between them. The stimulus produces it by streaming frames at 31 clocks per bit against a nominal 32, so every following start edge arrives a few ticks before the local stop bit would end. The stimulus acknowledges each byte early in the next start bit, which keeps overrun out of the result. Glitch tolerance uses a two-clock pulse timed to the bit centre, so exactly one oversample is flipped.

// File: rtl/ovs_uart_rx_pkg.sv
package ovs_uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeBit;
    logic deliver;
  } rxStrobe_t;

endpackage

// File: rtl/ovs_uart_rx_ctrl.sv
module ovs_uart_rx_ctrl
  import ovs_uart_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8,
  parameter int VOTE      = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      edgeSeen,
  input  logic      bitVal,
  output rxStrobe_t stb
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DATA_BITS + 1);
  localparam int DEC = OVS / 2 - 1 + VOTE;
  localparam logic [CW-1:0] DEC_T  = DEC[CW-1:0];
  localparam logic [CW-1:0] WRAP_T = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_T = BW'(DATA_BITS - 1);

  rxState_t        state;
  logic [CW-1:0]   tickCnt;
  logic [BW-1:0]   bitCnt;
  logic            atDec;

  assign atDec = tickEn && (tickCnt == DEC_T);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (tickEn) begin
      if (state == ST_HUNT) begin
        if (edgeSeen) begin
          state   <= ST_START;
          tickCnt <= '0;
        end
      end else begin
        tickCnt <= (tickCnt == WRAP_T) ? '0 : tickCnt + 1'b1;
        if (atDec) begin
          unique case (state)
            ST_START: begin
              bitCnt <= '0;
              state  <= bitVal ? ST_HUNT : ST_DATA;
            end
            ST_DATA: begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == LAST_T) state <= ST_STOP;
            end
            ST_STOP: state <= ST_HUNT;
            default: state <= ST_HUNT;
          endcase
        end
      end
    end
  end

  always_comb begin
    stb.takeBit = atDec && (state == ST_DATA);
    stb.deliver = atDec && (state == ST_STOP);
  end

  // R5
  rearm_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.deliver |=> (state == ST_HUNT));

  // R3
  runt_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && atDec && bitVal) |=> (state == ST_HUNT));

  // R2
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitCnt < BW'(DATA_BITS)));

  // R4
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(tickCnt));

endmodule

// File: rtl/ovs_uart_rx_dp.sv
module ovs_uart_rx_dp
  import ovs_uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int VOTE      = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 rxLine,
  input  logic                 ack,
  input  rxStrobe_t            stb,
  output logic                 edgeSeen,
  output logic                 bitVal,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxReady,
  output logic                 frameErr,
  output logic                 overrun
);
  logic                 syncA, lineS;
  logic                 prevS;
  logic [DATA_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b1;
      lineS <= 1'b1;
    end else begin
      syncA <= rxLine;
      lineS <= syncA;
    end
  end

  generate
    if (VOTE != 0) begin : g_vote
      logic [1:0] win;
      always_ff @(posedge clk) begin
        if (!rstN)       win <= 2'b11;
        else if (tickEn) win <= {win[0], lineS};
      end
      assign prevS  = win[0];
      assign bitVal = (win[1] & win[0]) | (win[1] & lineS) | (win[0] & lineS);
    end else begin : g_plain
      logic last;
      always_ff @(posedge clk) begin
        if (!rstN)       last <= 1'b1;
        else if (tickEn) last <= lineS;
      end
      assign prevS  = last;
      assign bitVal = lineS;
    end
  endgenerate

  assign edgeSeen = tickEn && prevS && !lineS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxData   <= '0;
      rxReady  <= 1'b0;
      frameErr <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (stb.takeBit) shiftReg <= {bitVal, shiftReg[DATA_BITS-1:1]};
      if (stb.deliver) begin
        rxData   <= shiftReg;
        frameErr <= !bitVal;
        rxReady  <= 1'b1;
      end else if (ack) begin
        rxReady <= 1'b0;
      end
      if (stb.deliver && rxReady && !ack) overrun <= 1'b1;
      else if (ack)                        overrun <= 1'b0;
    end
  end

  // R8
  ack_clears_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !stb.deliver) |=> !rxReady);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.deliver |=> $stable(rxData));

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !ack) |=> overrun);

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.deliver && rxReady && !ack) |=> overrun);

  // R2
  ready_on_deliver_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.deliver |=> rxReady);

endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx
  import ovs_uart_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8,
  parameter int VOTE      = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 rxLine,
  input  logic                 ack,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxReady,
  output logic                 frameErr,
  output logic                 overrun
);
  rxStrobe_t stb;
  logic      edgeSeen;
  logic      bitVal;

  ovs_uart_rx_ctrl #(.OVS(OVS), .DATA_BITS(DATA_BITS), .VOTE(VOTE)) i_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .edgeSeen(edgeSeen), .bitVal(bitVal), .stb(stb)
  );

  ovs_uart_rx_dp #(.DATA_BITS(DATA_BITS), .VOTE(VOTE)) i_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxLine(rxLine), .ack(ack),
    .stb(stb), .edgeSeen(edgeSeen), .bitVal(bitVal),
    .rxData(rxData), .rxReady(rxReady), .frameErr(frameErr), .overrun(overrun)
  );

endmodule

// File: tb/test_ovs_uart_rx.sv
module test_ovs_uart_rx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       rxLine = 1'b1;
  logic       ack = 1'b0;
  logic [7:0] rxData;
  logic       rxReady, frameErr, overrun;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic tickPh = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  // oversample strobe every second clock: 16 ticks = 32 clocks per bit
  always @(negedge clk) begin
    tickPh <= ~tickPh;
    tickEn <= tickPh;
  end

  ovs_uart_rx i_ovs_uart_rx (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxLine(rxLine), .ack(ack),
    .rxData(rxData), .rxReady(rxReady), .frameErr(frameErr), .overrun(overrun)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish (cycle %0d, expected < 190000)", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseAck();
    ack = 1'b1; waitClks(1); ack = 1'b0;
  endtask

  // one frame; optional mid-stop ready check, single-bit glitch, and
  // check/acknowledge of the previous byte early in the start bit
  task automatic sendFrame(input logic [7:0] b, input int bitClks,
                           input bit stopLow, input int glitchBit,
                           input bit chkMid, input bit chkPrev,
                           input logic [7:0] prevB);
    for (int k = 0; k < 10; k++) begin
      logic lvl;
      lvl = (k == 0) ? 1'b0 : (k == 9) ? !stopLow : b[k-1];
      rxLine = lvl;
      if (k == 0 && chkPrev) begin
        waitClks(1);
        chk("R5 stream byte", {rxReady, rxData}, {1'b1, prevB});
        pulseAck();
        waitClks(bitClks - 2);
      end else if (k == 9 && chkMid) begin
        waitClks(bitClks / 4);
        chk("R4 ready low early in stop", rxReady, 0);
        waitClks(bitClks / 2);
        chk("R4 ready high late in stop", rxReady, 1);
        waitClks(bitClks - bitClks / 4 - bitClks / 2);
      end else if (k == glitchBit) begin
        waitClks(bitClks / 2 - 1);
        rxLine = !lvl;
        waitClks(2);
        rxLine = lvl;
        waitClks(bitClks - bitClks / 2 - 1);
      end else begin
        waitClks(bitClks);
      end
    end
  endtask

  initial begin
    waitClks(5);
    rstN = 1'b1;
    waitClks(3);
    // R1
    chk("R1 reset state", {rxReady, frameErr, overrun, rxData}, 0);
    waitClks(20);

    // R2 R4 R8: all byte values at nominal rate
    for (int b = 0; b < 256; b++) begin
      sendFrame(8'(b), 32, 0, -1, 1, 0, 8'h00);
      waitClks(1);
      chk("R2 byte received", {rxReady, frameErr, overrun, rxData}, {3'b100, 8'(b)});
      pulseAck();
      chk("R8 ack clears ready", rxReady, 0);
      chk("R8 data held after ack", rxData, b);
    end
    waitClks(40);

    // R3: runt low pulse is ignored, then a real frame still works
    rxLine = 1'b0; waitClks(8); rxLine = 1'b1;
    waitClks(64);
    chk("R3 runt delivers nothing", rxReady, 0);
    sendFrame(8'hA5, 32, 0, -1, 0, 0, 8'h00);
    waitClks(1);
    chk("R3 frame after runt", {rxReady, rxData}, {1'b1, 8'hA5});
    pulseAck();
    waitClks(40);

    // R5: fast sender, back to back
    for (int i = 0; i < 12; i++)
      sendFrame(8'(i * 37 + 5), 31, 0, -1, 0, i > 0, 8'((i - 1) * 37 + 5));
    waitClks(1);
    chk("R5 fast last byte", {rxReady, overrun, rxData}, {2'b10, 8'(11 * 37 + 5)});
    pulseAck();
    waitClks(40);

    // R5: slow sender, back to back
    for (int i = 0; i < 12; i++)
      sendFrame(8'(i * 53 + 9), 33, 0, -1, 0, i > 0, 8'((i - 1) * 53 + 9));
    waitClks(1);
    chk("R5 slow last byte", {rxReady, overrun, rxData}, {2'b10, 8'(11 * 53 + 9)});
    pulseAck();
    waitClks(40);

    // R6: framing error, byte still delivered, cleared by next good frame
    sendFrame(8'h3C, 32, 1, -1, 0, 0, 8'h00);
    waitClks(1);
    chk("R6 framing error flagged", {rxReady, frameErr, rxData}, {2'b11, 8'h3C});
    rxLine = 1'b1;
    pulseAck();
    waitClks(40);
    sendFrame(8'hC3, 32, 0, -1, 0, 0, 8'h00);
    waitClks(1);
    chk("R6 framing error cleared", {rxReady, frameErr, rxData}, {2'b10, 8'hC3});
    pulseAck();
    waitClks(40);

    // R7: overrun
    sendFrame(8'h11, 32, 0, -1, 0, 0, 8'h00);
    waitClks(1);
    chk("R7 first byte no overrun", {overrun, rxData}, {1'b0, 8'h11});
    sendFrame(8'h22, 32, 0, -1, 0, 0, 8'h00);
    waitClks(1);
    chk("R7 overrun set and overwritten", {rxReady, overrun, rxData}, {2'b11, 8'h22});
    waitClks(30);
    chk("R7 overrun sticky", overrun, 1);
    pulseAck();
    chk("R7 ack clears overrun", {rxReady, overrun}, 0);
    waitClks(40);

    // R9: single-sample glitch at each data-bit centre
    for (int g = 1; g <= 8; g++) begin
      logic [7:0] v;
      v = (g % 2 == 0) ? 8'h00 : 8'hFF;
      v = v ^ 8'(g * 17);
      sendFrame(v, 32, 0, g, 0, 0, 8'h00);
      waitClks(1);
      chk("R9 glitch rejected", {rxReady, rxData}, {1'b1, v});
      pulseAck();
      waitClks(20);
    end

    summary();
  end
endmodule